// File: doc/BRIEF.md
# Serial Panel Power Sequencer

This block brings a display panel up or takes it down by replaying a fixed script of register writes over a three-wire, write-only serial link. The link has an active-low select line, a clock line and a data line. The select and clock lines both rest high, and the data line rests low. Every write is one 16-bit word. The register address occupies the upper byte and the value occupies the lower byte. The word is shifted out starting with its most significant bit, and the panel samples each bit on a rising clock edge.

A one-cycle pulse on `start_on` plays the five-write power-up script. A one-cycle pulse on `start_off` plays the single-write power-down script. `busy` is high for as long as a script runs. A one-cycle `done` pulse marks the end of a script. The block drops any request that arrives while `busy` is high. The `HALF_CYC` parameter sets, in system clock cycles, the shortest length of each serial clock phase. The same count sets the shortest idle gap on the select line between two words.

Top module: `panel_cfg_seq`

## Requirements
- R1: Each serial word is 16 bits, with the register address in bits 15..8 and the value in bits 7..0, and the data line presents bit 15 first and bit 0 last.
- R2: After a synchronous active-high reset, and whenever no script runs, the select line is high, the clock line is high, the data line is low, and busy and done are low.
- R3: When a word starts, the data line is already low and the clock line is high at the moment the select line falls.
- R4: Within a word the clock falls, the data line changes only together with that fall, and the data is held while the clock is high. Exactly 16 rising clock edges occur while select is low.
- R5: Each low clock phase, each high clock phase inside a word, and the time from the last rising edge to the select line rising all last at least HALF_CYC system cycles.
- R6: Between two words of one script, the select line stays high for at least HALF_CYC system cycles.
- R7: The power-up script sends, in this order, the words 0x051E, 0x055E, 0x078D, 0x1301 and 0x055F.
- R8: The power-down script sends the single word 0x055E.
- R9: A start request is accepted only when busy is low. A request that arrives while busy is high changes neither the words sent nor the length of the script that is running.
- R10: If start_on and start_off are pulsed in the same cycle while the block is idle, the power-up script is played.
- R11: busy is high from the cycle after an accepted request until done. done is a single-cycle pulse, issued after the select line has gone high following the last word, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_on | input | 1 | One-cycle request to play the power-up script |
| start_off | input | 1 | One-cycle request to play the power-down script |
| busy | output | 1 | A script is running |
| done | output | 1 | One-cycle pulse when a script has finished |
| pnl_sel_n | output | 1 | Serial select, active low, rests high |
| pnl_sclk | output | 1 | Serial clock, rests high; the panel samples on its rise |
| pnl_sdat | output | 1 | Serial data, rests low |

## Verification
The assertions assume that each request is a single-cycle pulse and that reset is held for at least one clock edge. They make no assumption about request timing relative to busy, because a request during busy must be dropped. The stimulus sends only one-cycle pulses, drives them on the falling system clock edge, and deliberately places pulses in the middle of running scripts and on both request inputs in the same cycle. The bench rebuilds every word from the serial lines alone and measures every phase length against HALF_CYC.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_BITS  = 8;
    localparam int VAL_BITS   = 8;
    localparam int ON_LEN     = 5;
    localparam int OFF_LEN    = 1;
    localparam int MAX_LEN    = (ON_LEN > OFF_LEN) ? ON_LEN : OFF_LEN;
    localparam int IDX_W      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [ADDR_BITS-1:0] addr;
        logic [VAL_BITS-1:0]  value;
    } reg_write_t;

    typedef enum logic {
        SCRIPT_UP   = 1'b0,
        SCRIPT_DOWN = 1'b1
    } script_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SETUP,
        TX_LOW,
        TX_HIGH,
        TX_GAP
    } tx_state_e;

    typedef enum logic {
        CT_IDLE,
        CT_RUN
    } ctl_state_e;

    function automatic reg_write_t make_write(input logic [ADDR_BITS-1:0] a,
                                              input logic [VAL_BITS-1:0] v);
        reg_write_t w;
        w.addr  = a;
        w.value = v;
        return w;
    endfunction

    function automatic reg_write_t script_entry(input script_e s,
                                                input logic [IDX_W-1:0] i);
        reg_write_t w;
        w = make_write(8'h00, 8'h00);
        if (s == SCRIPT_DOWN) begin
            w = make_write(8'h05, 8'h5E);
        end else begin
            case (i)
                3'd0:    w = make_write(8'h05, 8'h1E);
                3'd1:    w = make_write(8'h05, 8'h5E);
                3'd2:    w = make_write(8'h07, 8'h8D);
                3'd3:    w = make_write(8'h13, 8'h01);
                3'd4:    w = make_write(8'h05, 8'h5F);
                default: w = make_write(8'h00, 8'h00);
            endcase
        end
        return w;
    endfunction

    function automatic logic [IDX_W-1:0] script_last(input script_e s);
        return (s == SCRIPT_DOWN) ? IDX_W'(OFF_LEN - 1) : IDX_W'(ON_LEN - 1);
    endfunction

endpackage

// File: rtl/panel_script_rom.sv
module panel_script_rom
    import panel_seq_pkg::*;
(
    input  script_e          sel,
    input  logic [IDX_W-1:0] idx,
    output reg_write_t       word,
    output logic             is_last
);

    always_comb begin
        word    = script_entry(sel, idx);
        is_last = (idx == script_last(sel));
    end

endmodule

// File: rtl/panel_serial_tx.sv
module panel_serial_tx
    import panel_seq_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  frame_done,
    output logic                  sel_n,
    output logic                  sclk,
    output logic                  sdat
);

    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    tx_state_e             state;
    logic [CW-1:0]         cnt;
    logic [BIT_W-1:0]      bit_idx;
    logic [FRAME_BITS-1:0] shreg;
    logic                  phase_end;

    assign phase_end = (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= TX_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            sel_n      <= 1'b1;
            sclk       <= 1'b1;
            sdat       <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (state != TX_IDLE) begin
                cnt <= phase_end ? '0 : cnt + 1'b1;
            end
            unique case (state)
                TX_IDLE: begin
                    if (go) begin
                        shreg <= frame;
                        cnt   <= '0;
                        sel_n <= 1'b0;
                        state <= TX_SETUP;
                    end
                end
                TX_SETUP: begin
                    if (phase_end) begin
                        bit_idx <= '0;
                        sclk    <= 1'b0;
                        sdat    <= shreg[FRAME_BITS-1];
                        state   <= TX_LOW;
                    end
                end
                TX_LOW: begin
                    if (phase_end) begin
                        sclk  <= 1'b1;
                        state <= TX_HIGH;
                    end
                end
                TX_HIGH: begin
                    if (phase_end) begin
                        if (bit_idx == BIT_LAST) begin
                            sel_n <= 1'b1;
                            sdat  <= 1'b0;
                            state <= TX_GAP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                            sdat    <= shreg[FRAME_BITS-2];
                            sclk    <= 1'b0;
                            state   <= TX_LOW;
                        end
                    end
                end
                TX_GAP: begin
                    if (phase_end) begin
                        frame_done <= 1'b1;
                        state      <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    AST_DATA_LOW_AT_SELECT: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_n) |-> (!sdat && sclk)); // R3

    AST_DATA_HELD_CLOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk) && !sel_n && !$past(sel_n)) |-> $stable(sdat)); // R4

    AST_CLOCK_HIGH_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> sclk); // R2

    AST_SELECT_RISES_CLOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_n) |-> ($past(sclk) && !sdat)); // R5

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
    import panel_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_on,
    input  logic             start_off,
    input  logic             frame_done,
    input  logic             is_last,
    output script_e          sel,
    output logic [IDX_W-1:0] idx,
    output logic             tx_go,
    output logic             busy,
    output logic             done
);

    ctl_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CT_IDLE;
            sel   <= SCRIPT_UP;
            idx   <= '0;
            tx_go <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            tx_go <= 1'b0;
            done  <= 1'b0;
            unique case (state)
                CT_IDLE: begin
                    if (start_on || start_off) begin
                        sel   <= start_on ? SCRIPT_UP : SCRIPT_DOWN;
                        idx   <= '0;
                        tx_go <= 1'b1;
                        busy  <= 1'b1;
                        state <= CT_RUN;
                    end
                end
                CT_RUN: begin
                    if (frame_done) begin
                        if (is_last) begin
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            state <= CT_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            tx_go <= 1'b1;
                        end
                    end
                end
                default: state <= CT_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R11

    AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && (start_on || start_off)) |=> busy); // R9

    AST_BOTH_PICKS_UP: assert property (@(posedge clk) disable iff (rst)
        (!busy && state == CT_IDLE && start_on && start_off) |=> (sel == SCRIPT_UP)); // R10

    AST_SCRIPT_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sel)); // R9

endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
    import panel_seq_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_on,
    input  logic start_off,
    output logic busy,
    output logic done,
    output logic pnl_sel_n,
    output logic pnl_sclk,
    output logic pnl_sdat
);

    script_e          cur_sel;
    logic [IDX_W-1:0] cur_idx;
    reg_write_t       cur_word;
    logic             cur_last;
    logic             tx_go;
    logic             frame_done;

    panel_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_on   (start_on),
        .start_off  (start_off),
        .frame_done (frame_done),
        .is_last    (cur_last),
        .sel        (cur_sel),
        .idx        (cur_idx),
        .tx_go      (tx_go),
        .busy       (busy),
        .done       (done)
    );

    panel_script_rom u_rom (
        .sel     (cur_sel),
        .idx     (cur_idx),
        .word    (cur_word),
        .is_last (cur_last)
    );

    panel_serial_tx #(
        .HALF_CYC (HALF_CYC)
    ) u_tx (
        .clk        (clk),
        .rst        (rst),
        .go         (tx_go),
        .frame      (cur_word),
        .frame_done (frame_done),
        .sel_n      (pnl_sel_n),
        .sclk       (pnl_sclk),
        .sdat       (pnl_sdat)
    );

    AST_SELECT_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        !pnl_sel_n |-> busy); // R11

    AST_LINES_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pnl_sel_n && pnl_sclk && !pnl_sdat)); // R2

    initial begin
        assert (HALF_CYC >= 1);
    end

endmodule

// File: tb/panel_cfg_seq_test.sv
`timescale 1ns/1ps
module panel_cfg_seq_test;

    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_on = 1'b0;
    logic start_off = 1'b0;
    logic busy, done, sel_n, sclk, sdat;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    logic [15:0] cap [0:63];
    int n_frames = 0;
    int n_done = 0;

    logic [15:0] up_words [0:4];
    logic [15:0] down_word;

    always #5 clk = ~clk;

    panel_cfg_seq #(.HALF_CYC(HALF)) uut (
        .clk       (clk),
        .rst       (rst),
        .start_on  (start_on),
        .start_off (start_off),
        .busy      (busy),
        .done      (done),
        .pnl_sel_n (sel_n),
        .pnl_sclk  (sclk),
        .pnl_sdat  (sdat)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // serial line monitor: rebuilds words and measures phase lengths
    logic prev_sel = 1'b1, prev_clk = 1'b1, prev_dat = 1'b0, prev_done = 1'b0;
    int bits = 0;
    logic [15:0] sh = '0;
    int run = 0;
    int gap = 0;
    bit seen_word = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_sel && !sel_n) begin
                chk(sdat == 1'b0, "R3 data low at select fall", sdat, 0);
                chk(sclk == 1'b1, "R3 clock high at select fall", sclk, 1);
                chk(busy == 1'b1, "R11 busy during word", busy, 1);
                if (seen_word) chk(gap >= HALF, "R6 gap between words", gap, HALF);
                bits = 0;
                sh = '0;
                run = 1;
            end else if (!sel_n && !prev_sel) begin
                if (sclk != prev_clk) begin
                    chk(run >= HALF, prev_clk ? "R5 high phase" : "R5 low phase", run, HALF);
                    run = 1;
                end else begin
                    run++;
                end
                if (sclk && prev_clk && sdat != prev_dat)
                    chk(1'b0, "R4 data moved while clock high", sdat, prev_dat);
                if (!prev_clk && sclk) begin
                    sh = {sh[14:0], sdat};
                    bits++;
                end
                if (sclk == prev_clk && !sclk && sdat != prev_dat)
                    chk(1'b0, "R4 data moved while clock low", sdat, prev_dat);
            end
            if (!prev_sel && sel_n) begin
                chk(bits == 16, "R4 rising edges per word", bits, 16);
                chk(run >= HALF, "R5 last high phase", run, HALF);
                chk(sclk == 1'b1 && sdat == 1'b0, "R2 lines rest after word", {sclk, sdat}, 2);
                cap[n_frames % 64] = sh;
                n_frames++;
                gap = 1;
                seen_word = 1'b1;
            end else if (sel_n) begin
                gap++;
            end
            if (done) begin
                n_done++;
                chk(busy == 1'b0, "R11 busy low with done", busy, 0);
                chk(sel_n == 1'b1, "R11 select high at done", sel_n, 1);
                chk(prev_done == 1'b0, "R11 done single cycle", prev_done, 0);
            end
        end
        prev_sel = sel_n;
        prev_clk = sclk;
        prev_dat = sdat;
        prev_done = done;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !timed_out) begin
            timed_out = 1'b1;
            chk(1'b0, "watchdog expired", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic pulse(input bit on, input bit off);
        @(negedge clk);
        start_on = on;
        start_off = off;
        @(negedge clk);
        start_on = 1'b0;
        start_off = 1'b0;
    endtask

    // wait until done has been seen n times in total
    task automatic wait_done(input int target);
        int guard = 0;
        while (n_done < target && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // play a script and compare the words sent; optionally inject a request mid-run
    task automatic run_script(input bit on, input bit off, input bit up_expected,
                              input int inject_after, input bit inj_on, input bit inj_off,
                              input string tag);
        int base = n_frames;
        int dbase = n_done;
        int exp_len = up_expected ? 5 : 1;
        pulse(on, off);
        chk(busy == 1'b1, {tag, " R11 busy after accept"}, busy, 1);
        if (inject_after >= 0) begin
            while (n_frames - base < inject_after) @(negedge clk);
            repeat (2) @(negedge clk);
            chk(busy == 1'b1, {tag, " R9 still busy at injection"}, busy, 1);
            pulse(inj_on, inj_off);
        end
        wait_done(dbase + 1);
        chk(n_frames - base == exp_len, {tag, " R9 word count"}, n_frames - base, exp_len);
        for (int k = 0; k < exp_len; k++) begin
            logic [15:0] e;
            e = up_expected ? up_words[k] : down_word;
            chk(cap[(base + k) % 64] == e,
                {tag, up_expected ? " R7 up word" : " R8 down word", " R1 layout"},
                cap[(base + k) % 64], e);
        end
        repeat (4 * HALF + 10) @(negedge clk);
        chk(n_frames - base == exp_len && n_done == dbase + 1,
            {tag, " R9 no extra activity"}, n_frames - base, exp_len);
        chk(busy == 1'b0 && sel_n && sclk && !sdat, {tag, " R2 idle lines"},
            {busy, sel_n, sclk, sdat}, 4'b0110);
    endtask

    initial begin
        // register address in the upper byte, value in the lower byte
        up_words[0] = {8'h05, 8'h1E};
        up_words[1] = {8'h05, 8'h5E};
        up_words[2] = {8'h07, 8'h8D};
        up_words[3] = {8'h13, 8'h01};
        up_words[4] = {8'h05, 8'h5F};
        down_word   = {8'h05, 8'h5E};

        repeat (3) @(negedge clk);
        chk(sel_n == 1'b1, "R2 reset select", sel_n, 1);
        chk(sclk == 1'b1, "R2 reset clock", sclk, 1);
        chk(sdat == 1'b0, "R2 reset data", sdat, 0);
        chk(busy == 1'b0 && done == 1'b0, "R2 reset status", {busy, done}, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && sel_n == 1'b1, "R2 idle after reset", {busy, sel_n}, 1);

        run_script(1, 0, 1, -1, 0, 0, "up");
        run_script(0, 1, 0, -1, 0, 0, "down");
        run_script(1, 1, 1, -1, 0, 0, "R10 both");
        // sweep injection point across every word of the up script
        for (int p = 0; p < 5; p++) begin
            run_script(1, 0, 1, p, 0, 1, "R9 up+off");
            run_script(1, 0, 1, p, 1, 1, "R9 up+both");
        end
        run_script(0, 1, 0, 0, 1, 0, "R9 down+on");
        run_script(0, 1, 0, 0, 1, 1, "R9 down+both");

        // back-to-back: new request right after done is accepted
        run_script(0, 1, 0, -1, 0, 0, "down again");
        run_script(1, 0, 1, -1, 0, 0, "up again");

        // reset in the middle of a script returns lines to rest
        pulse(1, 0);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(sel_n && sclk && !sdat && !busy, "R2 reset mid script",
            {sel_n, sclk, sdat, busy}, 4'b1100);
        rst = 1'b0;
        seen_word = 1'b0;
        run_script(0, 1, 0, -1, 0, 0, "after reset");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule